// File: doc/BRIEF.md
# Infrared Transceiver Band Mode Sequencer

This block drives two pins of an infrared transceiver: the shutdown/mode pin and the transmit-data pin. The receiver inside the transceiver chooses its bandwidth from the level of the transmit-data pin at the moment the mode pin falls. A plain register write cannot select the band. The block therefore runs a timed two-pin handshake. On a start strobe it runs one of two sequences. The slow-band sequence covers 9.6 kbit/s up to 1.152 Mbit/s. The fast-band sequence covers 4 Mbit/s. It then reports completion and the band now in force.

All timing windows are counted in clock cycles. Each window is the required time divided by the clock period, rounded up, plus one cycle of margin. Outside a sequence the mode pin rests low and the transmit-data pin follows the user's serial data, so ordinary transmission passes straight through.

Top module: `irx_band_sequencer`

## Requirements
- R1: While reset is asserted and right after it, sd_mode is 0, busy is 0, done is 0, band_fast is 0 (slow band), and txd equals tx_data.
- R2: When no sequence is running, sd_mode stays 0 and txd follows tx_data in the same cycle.
- R3: A start with band_req=0 raises sd_mode in the cycle after the sampling edge. It holds sd_mode high with txd 0 for SLOW_HI cycles. It then holds sd_mode 0 with txd 0 for HOLD cycles.
- R4: A start with band_req=1 raises sd_mode with txd 0 for SETUP cycles. It then drives txd 1 while sd_mode stays high, so that sd_mode is high for FAST_HI cycles in total. It then holds sd_mode 0 with txd 1 for HOLD cycles, and txd returns to 0.
- R5: Each window in cycles is ceil(t_ns / CLK_PERIOD_NS) + 1, with setup t = 25 ns, hold t = 100 ns and pulse t = 50 ns. SLOW_HI is max(PULSE, SETUP) and FAST_HI is max(PULSE, 2*SETUP). Measured at the pins, the setup windows are at least 25 ns and the sd_mode high pulse lasts longer than 50 ns.
- R6: After the sd_mode falling edge, txd holds its band level for at least 100 ns.
- R7: busy is 1 from the cycle after an accepted start through the done cycle. done is a single-cycle pulse after the hold window, with sd_mode 0 and txd 0.
- R8: A start seen while busy is 1 is ignored, together with its band_req value.
- R9: While busy is 1, tx_data has no effect on txd.
- R10: band_fast (1 = fast band) takes the requested band in the cycle where done is 1, and changes at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start strobe, sampled while idle |
| band_req | input | 1 | Requested band: 1 fast, 0 slow |
| tx_data | input | 1 | User serial data, passed to txd when idle |
| sd_mode | output | 1 | Shutdown/mode pin level |
| txd | output | 1 | Transmit-data pin level |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| band_fast | output | 1 | Band currently programmed |

## Verification
A wrong state or count shows at the pins within one clock. It can appear as an sd_mode edge one cycle early or late, or as txd at the wrong level for the band. It can also appear as tx_data leaking onto txd during a sequence. A reference model in the bench predicts every pin on every cycle, so such a slip fails at the first cycle where it appears. A request latched at the wrong time, or a lost start, shows as band_fast holding the wrong value after done. The bench checks that too. Edge-to-edge intervals are measured separately against the nanosecond minimums of both sequences.

// File: rtl/irx_band_sequencer.sv
module irx_band_sequencer #(
  parameter int CLK_PERIOD_NS = 20,
  parameter int T_SETUP_NS    = 25,
  parameter int T_HOLD_NS     = 100,
  parameter int T_PULSE_NS    = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic band_req,
  input  logic tx_data,
  output logic sd_mode,
  output logic txd,
  output logic busy,
  output logic done,
  output logic band_fast
);
  localparam int SETUP_CYC = (T_SETUP_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS + 1;
  localparam int HOLD_CYC  = (T_HOLD_NS  + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS + 1;
  localparam int PULSE_CYC = (T_PULSE_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS + 1;
  localparam int SLOW_HI   = (PULSE_CYC > SETUP_CYC) ? PULSE_CYC : SETUP_CYC;
  localparam int FAST_HI   = (PULSE_CYC > 2 * SETUP_CYC) ? PULSE_CYC : 2 * SETUP_CYC;
  localparam int FAST_TAIL = FAST_HI - SETUP_CYC;
  localparam int MAX_CYC   = SLOW_HI + FAST_HI + HOLD_CYC;
  localparam int CW        = $clog2(MAX_CYC + 1);

  typedef enum logic [2:0] {IDLE, SD_HIGH, TXD_SETUP, SD_LOW_HOLD, DONE} state_t;

  state_t        state;
  logic [CW-1:0] cnt;
  logic          req_q;
  logic          last;

  assign last = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= IDLE;
      cnt       <= '0;
      req_q     <= 1'b0;
      band_fast <= 1'b0;
    end else begin
      case (state)
        IDLE: if (start) begin
          req_q <= band_req;
          cnt   <= band_req ? CW'(SETUP_CYC - 1) : CW'(SLOW_HI - 1);
          state <= SD_HIGH;
        end
        SD_HIGH: if (last) begin
          if (req_q) begin
            cnt   <= CW'(FAST_TAIL - 1);
            state <= TXD_SETUP;
          end else begin
            cnt   <= CW'(HOLD_CYC - 1);
            state <= SD_LOW_HOLD;
          end
        end else cnt <= cnt - 1'b1;
        TXD_SETUP: if (last) begin
          cnt   <= CW'(HOLD_CYC - 1);
          state <= SD_LOW_HOLD;
        end else cnt <= cnt - 1'b1;
        SD_LOW_HOLD: if (last) begin
          band_fast <= req_q;
          state     <= DONE;
        end else cnt <= cnt - 1'b1;
        DONE: state <= IDLE;
        default: state <= IDLE;
      endcase
    end
  end

  assign busy    = (state != IDLE);
  assign done    = (state == DONE);
  assign sd_mode = (state == SD_HIGH) || (state == TXD_SETUP);
  assign txd     = (state == IDLE) ? tx_data
                 : ((state == TXD_SETUP) || (state == SD_LOW_HOLD && req_q));

  logic [CW-1:0] hi_run;
  logic [CW-1:0] lo_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run <= '0;
      lo_run <= '0;
    end else begin
      hi_run <= sd_mode ? hi_run + 1'b1 : '0;
      lo_run <= (sd_mode || !busy || done) ? '0 : lo_run + 1'b1;
    end
  end

  AST_PULSE_MIN:   assert property (@(posedge clk) disable iff (!rst_n)
                     $fell(sd_mode) |-> hi_run >= CW'(PULSE_CYC)); // R5
  AST_HOLD_MIN:    assert property (@(posedge clk) disable iff (!rst_n)
                     done |-> lo_run >= CW'(HOLD_CYC)); // R6
  AST_SD_FALL_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
                     $fell(sd_mode) |-> busy); // R3
  AST_TXD_RISE_SD: assert property (@(posedge clk) disable iff (!rst_n)
                     (busy && $rose(txd)) |-> sd_mode); // R4
  AST_DONE_PULSE:  assert property (@(posedge clk) disable iff (!rst_n)
                     done |=> !done); // R7
  AST_REQ_LOCKED:  assert property (@(posedge clk) disable iff (!rst_n)
                     ($past(busy) && busy) |-> $stable(req_q)); // R8
  AST_BAND_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
                     !$stable(band_fast) |-> done); // R10
endmodule

// File: tb/irx_band_sequencer_tb.sv
module irx_band_sequencer_tb_top;
  localparam int PER = 20;
  localparam int SETUP = (25 + PER - 1) / PER + 1;
  localparam int HOLD  = (100 + PER - 1) / PER + 1;
  localparam int PULSE = (50 + PER - 1) / PER + 1;
  localparam int SLOW_HI = (PULSE > SETUP) ? PULSE : SETUP;
  localparam int FAST_HI = (PULSE > 2 * SETUP) ? PULSE : 2 * SETUP;

  logic clk = 0, rst_n = 0, start = 0, band_req = 0, tx_data = 0;
  logic sd_mode, txd, busy, done, band_fast;
  int checks = 0, fails = 0, cyc = 0;

  always #(PER / 2) clk = ~clk;

  irx_band_sequencer #(.CLK_PERIOD_NS(PER)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .band_req(band_req), .tx_data(tx_data),
    .sd_mode(sd_mode), .txd(txd), .busy(busy), .done(done), .band_fast(band_fast));

  typedef struct { bit busy; bit done; bit sd; int txc; int nm; bit fast; } ent_t;
  ent_t q[$];
  ent_t cur;
  bit exp_mode;

  function automatic ent_t mk(bit b, bit d, bit s, int t, int nm, bit f);
    ent_t e; e.busy = b; e.done = d; e.sd = s; e.txc = t; e.nm = nm; e.fast = f; return e;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp, string what);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp); end
  endtask

  // reference model: one schedule entry per cycle
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete(); cur = mk(0, 0, 0, 2, -1, 0); exp_mode = 0;
    end else if (q.size() > 0) cur = q.pop_front();
    else if (!cur.busy && start) begin
      if (band_req) begin
        for (int i = 0; i < SETUP; i++) q.push_back(mk(1, 0, 1, 0, -1, 1));
        for (int i = 0; i < FAST_HI - SETUP; i++) q.push_back(mk(1, 0, 1, 1, -1, 1));
        for (int i = 0; i < HOLD; i++) q.push_back(mk(1, 0, 0, 1, -1, 1));
        q.push_back(mk(1, 1, 0, 0, 1, 1));
      end else begin
        for (int i = 0; i < SLOW_HI; i++) q.push_back(mk(1, 0, 1, 0, -1, 0));
        for (int i = 0; i < HOLD; i++) q.push_back(mk(1, 0, 0, 0, -1, 0));
        q.push_back(mk(1, 1, 0, 0, 0, 0));
      end
      cur = q.pop_front();
    end else cur = mk(0, 0, 0, 2, -1, 0);
    if (rst_n && cur.nm >= 0) exp_mode = cur.nm[0];
  end

  // per-cycle comparison and pin interval measurement
  int sd_rise, tx_rise, sd_fall;
  bit p_sd = 0, p_tx = 0, p_busy = 0;
  always @(posedge clk) begin
    #5;
    cyc++;
    if (rst_n) begin
      automatic string seq = cur.busy ? (cur.fast ? "R4" : "R3") : "R2";
      automatic bit etx = (cur.txc == 2) ? tx_data : cur.txc[0];
      chk(sd_mode == cur.sd, seq, sd_mode, cur.sd, "sd_mode");
      chk(txd == etx, cur.busy ? "R9" : "R2", txd, etx, "txd");
      chk(busy == cur.busy, "R7", busy, cur.busy, "busy");
      chk(done == cur.done, "R7", done, cur.done, "done");
      chk(band_fast == exp_mode, "R10", band_fast, exp_mode, "band_fast");
      if (busy && sd_mode && !p_sd) sd_rise = cyc;
      if (busy && txd && !p_tx && p_busy) tx_rise = cyc;
      if (busy && !sd_mode && p_sd) sd_fall = cyc;
      if (done) begin
        chk((sd_fall - sd_rise) * PER > 50, "R5", (sd_fall - sd_rise) * PER, 51, "sd pulse ns");
        if (cur.fast) begin
          chk((tx_rise - sd_rise) * PER > 25, "R5", (tx_rise - sd_rise) * PER, 26, "sd->txd setup ns");
          chk((sd_fall - tx_rise) * PER >= 25, "R5", (sd_fall - tx_rise) * PER, 25, "txd->sd setup ns");
        end else
          chk((sd_fall - sd_rise) * PER >= 25, "R5", (sd_fall - sd_rise) * PER, 25, "slow setup ns");
        chk((cyc - sd_fall) * PER >= 100, "R6", (cyc - sd_fall) * PER, 100, "hold ns");
      end
      p_sd = sd_mode; p_tx = txd; p_busy = busy;
    end
  end

  task automatic drive(bit s, bit r, bit t);
    @(negedge clk); start = s; band_req = r; tx_data = t;
  endtask

  bit finished = 0;
  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * PER);
    fails++; $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #5;
    // R1: reset state
    chk(sd_mode == 0 && busy == 0 && done == 0 && band_fast == 0, "R1", {sd_mode, busy, done, band_fast}, 0, "reset outputs");
    tx_data = 1; #1;
    chk(txd == 1, "R1", txd, 1, "txd under reset");
    @(negedge clk); rst_n = 1; tx_data = 0;
    // R2: idle pass-through
    for (int i = 0; i < 6; i++) drive(0, 0, i[0]);
    // R3 slow sequence, R9 tx_data toggles during it
    drive(1, 0, 1);
    for (int i = 0; i < 12; i++) drive(0, 1, i[0]);
    // R4 fast sequence, R8 start with slow request mid-sequence
    drive(1, 1, 0);
    for (int i = 0; i < 4; i++) drive(0, 0, 1);
    drive(1, 0, 1);
    for (int i = 0; i < 10; i++) drive(0, 0, i[0]);
    // R8: ignored start must leave the fast band in force
    #5; chk(band_fast == 1, "R8", band_fast, 1, "band after ignored start");
    // start held high: back-to-back sequences, slow then fast
    drive(1, 0, 0);
    for (int i = 0; i < 12; i++) drive(1, 1, 1);
    for (int i = 0; i < 14; i++) drive(0, 0, 0);
    #5; chk(band_fast == 1, "R10", band_fast, 1, "band after held start");
    drive(1, 0, 0);
    for (int i = 0; i < 13; i++) drive(0, 0, 1);
    #5; chk(band_fast == 0, "R10", band_fast, 0, "band back to slow");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule